// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block sits between a host bus and a word-addressed memory array and turns single start addresses into synchronous read streams. After reset it works in pass-through mode: the array address follows the host address in the same cycle, and every read is a plain random read. When the burst-mode enable is held high, the block registers a start address whenever the load strobe is sampled low. It then waits a fixed number of clock cycles for the first array access to settle. After that wait, it presents one new word for every clock edge on which the advance strobe is low.

The address stream stays inside the aligned 32-word window that holds the start address. The low five address bits count upward and roll over from 31 to 0, while the upper bits stay fixed. A separate active-low end-of-window indicator marks the word at offset 31. A host that does not want wrapped data reloads with the next window's address, and a reload is taken at any time.

Top module: `wbr_top`

## Requirements
- R1: While `rst_n` is low, the block is in pass-through mode, `dvalid` is 0 and `eow_n` is 1.
- R2: While pass-through mode is in effect, `arr_addr` equals `addr_in` in the same cycle, `dvalid` stays 0 and `eow_n` stays 1, whatever `load_n` and `adv_n` do.
- R3: `burst_en` is sampled on each rising edge. After an edge with it high, burst mode is in effect; after an edge with it low, pass-through mode is in effect. Before the first load in burst mode, `arr_addr` is 0.
- R4: In burst mode, an edge with `load_n` low captures `addr_in`, and `arr_addr` shows that address after the edge.
- R5: `dvalid` is 0 after a load edge and rises after exactly `INIT_LAT` further edges (default 4). During that wait, `adv_n` has no effect on `arr_addr`.
- R6: An edge with `dvalid` high, `adv_n` low and `load_n` high adds one to `arr_addr[4:0]`, rolling over from 31 to 0, and leaves `arr_addr[19:5]` unchanged. Beyond 32 advances the sequence repeats.
- R7: `eow_n` is 0 exactly when `dvalid` is 1 and `arr_addr[4:0]` is 31; otherwise it is 1.
- R8: A load is accepted at any point of a burst, including during the wait. When `load_n` and `adv_n` are both low on an edge, the load wins.
- R9: An edge with `adv_n` high and `load_n` high in burst mode leaves `arr_addr` and `eow_n` unchanged.
- R10: `dout` carries `rd_data`, the array word at `arr_addr`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | 1 selects burst mode, 0 selects pass-through mode |
| load_n | input | 1 | Active-low start-address load strobe |
| adv_n | input | 1 | Active-low advance strobe |
| addr_in | input | 20 | Host word address |
| rd_data | input | 16 | Word read from the array at `arr_addr` |
| arr_addr | output | 20 | Read address driven to the array |
| dout | output | 16 | Output word |
| dvalid | output | 1 | High when a burst word is valid |
| eow_n | output | 1 | Active-low end-of-window indicator (offset 31) |

## Verification
The embedded properties assume that:
- the strobes and `burst_en` are stable around the rising edge;
- the array returns `rd_data` combinationally from `arr_addr`.

The hold property also assumes that `burst_en` stays high across the cycle being checked.

The stimulus changes every input only on the falling edge. It models the array as a fixed function of `arr_addr`, and it lowers `burst_en` only at steps that expect a mode change. The sweep covers:
- every start offset within a window;
- more than 32 advances per offset, with held cycles mixed in;
- reloads in the middle of a burst;
- loads and advances on the same edge.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int ADDR_W = 20;
  localparam int WIN_W  = 5;
  localparam int BASE_W = ADDR_W - WIN_W;
  localparam int DATA_W = 16;

  typedef logic [WIN_W-1:0]  win_off_t;
  typedef logic [BASE_W-1:0] win_base_t;
  typedef logic [ADDR_W-1:0] waddr_t;
endpackage

// File: rtl/wbr_win_ctr.sv
module wbr_win_ctr
  import wbr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      load_en,
  input  logic      adv_en,
  input  waddr_t    start,
  output win_base_t base_q,
  output win_off_t  off_q
);
  win_base_t base_d;
  win_off_t  off_d;
  logic      upd;

  always_comb begin
    base_d = base_q;
    off_d  = off_q;
    if (clr) begin
      base_d = '0;
      off_d  = '0;
    end else if (load_en) begin
      base_d = start[ADDR_W-1:WIN_W];
      off_d  = start[WIN_W-1:0];
    end else if (adv_en) begin
      off_d  = off_q + 1'b1;
    end
  end

  assign upd = clr | load_en | adv_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (upd) begin
      base_q <= base_d;
      off_q  <= off_d;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en && !clr && off_q == '1) |=> (off_q == '0)); // R6

  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !clr) |=> $stable(base_q)); // R6
endmodule

// File: rtl/wbr_lat_timer.sv
module wbr_lat_timer #(
  parameter int INIT_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic ready
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (clr)        armed_d = 1'b0;
    else if (start) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed_q <= 1'b0;
    else if (clr || start)  armed_q <= armed_d;
  end

  generate
    if (INIT_LAT == 0) begin : g_nowait
      assign ready = armed_q;
    end else begin : g_wait
      localparam int CNT_W = $clog2(INIT_LAT + 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_d = cnt_q;
        if (clr)                cnt_d = '0;
        else if (start)         cnt_d = CNT_W'(INIT_LAT);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
      end

      assign cnt_en = clr | start | (cnt_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign ready = armed_q && (cnt_q == '0);

      AST_WAIT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready); // R5

      AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
    end
  endgenerate
endmodule

// File: rtl/wbr_eow_flag.sv
module wbr_eow_flag
  import wbr_pkg::*;
(
  input  logic     valid,
  input  win_off_t off,
  output logic     eow_n
);
  logic at_last;

  assign at_last = (off == '1);
  assign eow_n   = ~(valid & at_last);

  always_comb begin
    if (!eow_n) AST_EOW_NEEDS_VALID: assert (valid); // R7
  end
endmodule

// File: rtl/wbr_top.sv
module wbr_top
  import wbr_pkg::*;
#(
  parameter int INIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_en,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid,
  output logic              eow_n
);
  logic      mode_q, mode_d;
  logic      clr, load_acc, adv_acc, ready;
  win_base_t base_q;
  win_off_t  off_q;

  assign mode_d = burst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign clr      = ~mode_q;
  assign load_acc = mode_q & ~load_n;
  assign adv_acc  = mode_q & ready & ~adv_n & load_n;

  wbr_win_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .load_en (load_acc),
    .adv_en  (adv_acc),
    .start   (addr_in),
    .base_q  (base_q),
    .off_q   (off_q)
  );

  wbr_lat_timer #(.INIT_LAT(INIT_LAT)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .start (load_acc),
    .ready (ready)
  );

  assign dvalid = mode_q & ready;

  wbr_eow_flag u_eow (
    .valid (dvalid),
    .off   (off_q),
    .eow_n (eow_n)
  );

  assign arr_addr = mode_q ? {base_q, off_q} : addr_in;
  assign dout     = rd_data;

  AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (!dvalid && eow_n)); // R2

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && burst_en && dvalid && load_n && adv_n) |=>
      ($stable(arr_addr) && $stable(eow_n))); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && burst_en && !load_n) |=> (arr_addr == $past(addr_in))); // R8
endmodule

// File: tb/wbr_top_test.sv
module wbr_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n, burst_en, load_n, adv_n;
  logic [19:0] addr_in, arr_addr;
  logic [15:0] rd_data, dout;
  logic        dvalid, eow_n;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = arr_addr[15:0] ^ 16'hA5C3;

  wbr_top #(.INIT_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .load_n(load_n),
    .adv_n(adv_n), .addr_in(addr_in), .rd_data(rd_data),
    .arr_addr(arr_addr), .dout(dout), .dvalid(dvalid), .eow_n(eow_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic ld, input logic adv, input logic [19:0] a);
    @(negedge clk);
    load_n = ld; adv_n = adv; addr_in = a;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk_word(input logic [19:0] ea, input logic ev, input string req);
    chk(arr_addr == ea, req, 32'(arr_addr), 32'(ea));
    chk(dvalid == ev, req, 32'(dvalid), 32'(ev));
    chk(eow_n == !(ev && ea[4:0] == 5'd31), {req, "/R7"}, 32'(eow_n), 32'(!(ev && ea[4:0] == 5'd31)));
    chk(dout == (ea[15:0] ^ 16'hA5C3), {req, "/R10"}, 32'(dout), 32'(ea[15:0] ^ 16'hA5C3));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [14:0] b;
    logic [4:0]  eo;
    rst_n = 1'b0; burst_en = 1'b0; load_n = 1'b1; adv_n = 1'b1; addr_in = 20'h12345;
    #(CLK_PERIOD * 2 + 1);
    // R1: reset state
    chk(dvalid == 1'b0, "R1 dvalid", 32'(dvalid), 0);
    chk(eow_n == 1'b1, "R1 eow_n", 32'(eow_n), 1);
    chk(arr_addr == addr_in, "R1 pass-through", 32'(arr_addr), 32'(addr_in));
    @(negedge clk); rst_n = 1'b1;

    // R2: pass-through sweep with strobes toggling
    for (int i = 0; i < 24; i++) begin
      cyc(i[0], i[1], 20'(i * 20'h0A3F1 + 7));
      chk_word(20'(i * 20'h0A3F1 + 7), 1'b0, "R2 async");
    end

    // R3: entering burst mode, no load yet
    @(negedge clk); burst_en = 1'b1;
    cyc(1'b1, 1'b1, 20'hFFFFF);
    chk_word(20'h0, 1'b0, "R3 enter");

    // R4 R5 R6 R9: every start offset
    for (int o = 0; o < 32; o++) begin
      b = 15'(o * 37 + 5);
      cyc(1'b0, 1'b1, {b, 5'(o)});
      chk_word({b, 5'(o)}, 1'b0, "R4 load");
      for (int w = 1; w < LAT; w++) begin
        cyc(1'b1, 1'b0, 20'h0);
        chk_word({b, 5'(o)}, 1'b0, "R5 wait");
      end
      cyc(1'b1, 1'b0, 20'h0);
      chk_word({b, 5'(o)}, 1'b1, "R5 first word");
      eo = 5'(o);
      for (int k = 1; k <= 40; k++) begin
        if (k % 7 == 3) begin
          cyc(1'b1, 1'b1, 20'h0);
          chk_word({b, eo}, 1'b1, "R9 hold");
        end else begin
          cyc(1'b1, 1'b0, 20'h0);
          eo = eo + 5'd1;
          chk_word({b, eo}, 1'b1, "R6 advance");
        end
      end
    end

    // R8: reload mid-stream with advance on same edge
    cyc(1'b0, 1'b0, 20'hABCDE);
    chk_word(20'hABCDE, 1'b0, "R8 load wins");
    cyc(1'b1, 1'b0, 20'h0);
    cyc(1'b0, 1'b0, 20'h4321F);
    chk_word(20'h4321F, 1'b0, "R8 reload during wait");
    for (int w = 0; w < LAT; w++) cyc(1'b1, 1'b1, 20'h0);
    chk_word(20'h4321F, 1'b1, "R8 reloaded stream");
    cyc(1'b1, 1'b0, 20'h0);
    chk_word(20'h43200, 1'b1, "R8 wrap after reload");

    // R3: leaving burst mode
    @(negedge clk); burst_en = 1'b0;
    cyc(1'b0, 1'b0, 20'h55555);
    chk_word(20'h55555, 1'b0, "R3 exit");
    cyc(1'b1, 1'b1, 20'h0F0F0);
    chk_word(20'h0F0F0, 1'b0, "R3 async again");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule